// File: doc/BRIEF.md
# Serial EEPROM station address reader

The block fetches a 48-bit network station address from a two-wire serial EEPROM. A single pulse on `start_i` launches a fixed random-read transaction. The block sends a start condition, the write control byte 0xA0 and a one-byte word address. It then sends a repeated start and the read control byte 0xA1, and clocks in six data bytes. When the bytes have been read, or when the EEPROM fails to acknowledge, a stop condition ends the transaction. The result is then held on `addr_o` together with the `done_o` and `err_o` flags.

The word address comes from a 2-bit board selector, which picks one of four preset locations. The clock pin is meant for an open-drain pad. The data pin has a separate output enable, so the block can release the line and read what the EEPROM drives. Each half period of the serial clock lasts a programmable number of system clocks, with a floor of two. Both the selector and the divider are latched when a transaction starts.

Top module: `eeprom_mac_reader`

## Requirements
- R1: A `start_i` pulse while idle begins a transaction and clears `done_o`, `err_o` and `addr_o` to zero. A `start_i` pulse during a transaction has no effect on the pin waveform or on the result.
- R2: Every waveform step lasts max(`half_div_i`, 2) system clocks. The value is latched at the accepting edge, and the first step appears in the cycle after that edge.
- R3: A start condition is four steps of (`scl_o`,`sda_oe_o`,`sda_o`): (0,1,1), (1,1,1), (1,1,0), (0,1,0). The data driver stays enabled when it ends.
- R4: Bytes are sent MSB first, in this order: 0xA0, then the word address, then (after a repeated start) 0xA1. The word address is 0x83, 0x99, 0xAF or 0xF8 for `base_sel_i` = 0, 1, 2 or 3.
- R5: Each sent bit is two steps, (0,1,b) and then (1,1,b).
- R6: After each sent byte comes an acknowledge slot of two steps, (0,1... released): (0,0,0) and then (1,0,0). `sda_i` is sampled on the last system clock of the second step, and low means acknowledged.
- R7: A high acknowledge sets `err_o` in the cycle after it is sampled and starts the stop condition at once. `addr_o` then stays zero.
- R8: Each received bit is two steps, (0,0,0) and then (1,0,0), sampled at the end of the second step. The first bit received ends up in `addr_o[47]`, and later bits fill lower positions in order.
- R9: After each of the first five received bytes the block sends an acknowledge bit of 0. After the sixth byte it sends 1. Both use the sent-bit steps of R5.
- R10: A stop condition is six steps: (0,0,0), (1,0,0), (1,1,0), (1,1,1), (1,0,1), (0,0,1).
- R11: `done_o` rises in the cycle after the last stop step and holds until the next accepted start. While idle, and after reset, `scl_o`, `sda_oe_o` and `sda_o` are 0, and `done_o`, `err_o` and `addr_o` are 0 after reset.
- R12: Outside start and stop conditions, the level on the data line (driven value, or high when released) never changes while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a read when idle |
| base_sel_i | input | 2 | Word address selector |
| half_div_i | input | DIV_W | System clocks per serial half period (floor 2) |
| sda_i | input | 1 | Sensed data line level |
| scl_o | output | 1 | Serial clock level for the open-drain pad |
| sda_o | output | 1 | Data value to drive |
| sda_oe_o | output | 1 | Data driver enable |
| addr_o | output | 8*ADDR_BYTES | Assembled station address |
| done_o | output | 1 | Transaction finished |
| err_o | output | 1 | EEPROM did not acknowledge |

## Verification
The pin waveform is tried with all four selector values, which tells apart the word address bytes that get shifted out. Divider settings of 0, 1, 2, 3 and 5 separate the floor of two from a plain count. Data patterns are chosen so that a byte-order or bit-order slip shows up: incrementing bytes, alternating bits, a half-ones/half-zeros split and single set bits at both ends. Missing acknowledges are injected after each of the three sent bytes, to show that the abort is taken at the right slot and that the result stays cleared. One run also pulses start in the middle of the transaction.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

  typedef enum logic [2:0] {
    K_IDLE,
    K_START,
    K_TXB,
    K_RXB,
    K_STOP
  } step_kind_e;

  localparam logic [7:0] CTL_WR = 8'hA0;
  localparam logic [7:0] CTL_RD = 8'hA1;

  function automatic logic [7:0] base_addr(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'h83;
      2'd1:    return 8'h99;
      2'd2:    return 8'hAF;
      default: return 8'hF8;
    endcase
  endfunction

endpackage

// File: rtl/eeprom_rd_pace.sv
module eeprom_rd_pace #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);

  logic [DIV_W-1:0] per_q, cnt_q;

  assign tick_o = run_i && (cnt_q == per_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= MIN_HALF;
      cnt_q <= '0;
    end else if (load_i) begin
      per_q <= (div_i < MIN_HALF) ? MIN_HALF : div_i;
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  p_half_floor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (per_q >= MIN_HALF));

  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/eeprom_rd_capture.sv
module eeprom_rd_capture #(
  parameter int W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (clear_i) data_o <= '0;
    else if (shift_i) data_o <= {data_o[W-2:0], bit_i};
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !shift_i) |=> $stable(data_o));

  p_shift_in_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !clear_i) |=> (data_o[0] == $past(bit_i)));

endmodule

// File: rtl/eeprom_rd_seq.sv
module eeprom_rd_seq
  import eeprom_rd_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] base_sel_i,
  input  logic       tick_i,
  input  logic       sda_i,
  output logic       load_o,
  output logic       busy_o,
  output logic       shift_o,
  output logic       scl_o,
  output logic       sda_o,
  output logic       sda_oe_o,
  output logic       done_o,
  output logic       err_o
);
  // segment order: start, wr ctl, word addr, restart, rd ctl, data bytes, stop
  localparam int SEG_RS   = 3;
  localparam int SEG_RD0  = 5;
  localparam int SEG_STOP = SEG_RD0 + ADDR_BYTES;
  localparam int SEG_W    = $clog2(SEG_STOP + 1);

  logic             busy_q, done_q, err_q;
  logic [SEG_W-1:0] seg_q;
  logic [3:0]       bit_q;
  logic [2:0]       ph_q;
  logic [1:0]       sel_q;
  step_kind_e       kind;
  logic [7:0]       tx_byte;
  logic             slot, line;

  assign load_o   = start_i && !busy_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign slot     = (bit_q == 4'd8);
  assign shift_o  = tick_i && (kind == K_RXB) && ph_q[0] && !slot;

  always_comb begin
    kind = K_IDLE;
    if (busy_q) begin
      if (seg_q == 0 || seg_q == SEG_W'(SEG_RS)) kind = K_START;
      else if (seg_q < SEG_W'(SEG_RD0))          kind = K_TXB;
      else if (seg_q < SEG_W'(SEG_STOP))         kind = K_RXB;
      else                                        kind = K_STOP;
    end
  end

  always_comb begin
    case (seg_q)
      SEG_W'(1): tx_byte = CTL_WR;
      SEG_W'(2): tx_byte = base_addr(sel_q);
      default:   tx_byte = CTL_RD;
    endcase
  end

  always_comb begin
    {scl_o, sda_oe_o, sda_o} = 3'b000;
    case (kind)
      K_START: case (ph_q)
        3'd0:    {scl_o, sda_oe_o, sda_o} = 3'b011;
        3'd1:    {scl_o, sda_oe_o, sda_o} = 3'b111;
        3'd2:    {scl_o, sda_oe_o, sda_o} = 3'b110;
        default: {scl_o, sda_oe_o, sda_o} = 3'b010;
      endcase
      K_TXB: begin
        scl_o = ph_q[0];
        if (!slot) begin
          sda_oe_o = 1'b1;
          sda_o    = tx_byte[~bit_q[2:0]];
        end
      end
      K_RXB: begin
        scl_o = ph_q[0];
        if (slot) begin
          sda_oe_o = 1'b1;
          sda_o    = (seg_q == SEG_W'(SEG_STOP - 1));
        end
      end
      K_STOP: case (ph_q)
        3'd0:    {scl_o, sda_oe_o, sda_o} = 3'b000;
        3'd1:    {scl_o, sda_oe_o, sda_o} = 3'b100;
        3'd2:    {scl_o, sda_oe_o, sda_o} = 3'b110;
        3'd3:    {scl_o, sda_oe_o, sda_o} = 3'b111;
        3'd4:    {scl_o, sda_oe_o, sda_o} = 3'b101;
        default: {scl_o, sda_oe_o, sda_o} = 3'b001;
      endcase
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      seg_q  <= '0;
      bit_q  <= '0;
      ph_q   <= '0;
      sel_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      seg_q  <= '0;
      bit_q  <= '0;
      ph_q   <= '0;
      sel_q  <= base_sel_i;
    end else if (busy_q && tick_i) begin
      case (kind)
        K_START: begin
          if (ph_q == 3'd3) begin
            ph_q  <= '0;
            bit_q <= '0;
            seg_q <= seg_q + 1'b1;
          end else ph_q <= ph_q + 1'b1;
        end
        K_TXB, K_RXB: begin
          if (!ph_q[0]) ph_q <= 3'd1;
          else begin
            ph_q <= '0;
            if (!slot) bit_q <= bit_q + 1'b1;
            else begin
              bit_q <= '0;
              if (kind == K_TXB && sda_i) begin
                err_q <= 1'b1;
                seg_q <= SEG_W'(SEG_STOP);
              end else seg_q <= seg_q + 1'b1;
            end
          end
        end
        K_STOP: begin
          if (ph_q == 3'd5) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else ph_q <= ph_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign line = sda_oe_o ? sda_o : 1'b1;

  p_data_steady_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o && $past(scl_o) && (kind == K_TXB || kind == K_RXB)) |-> (line == $past(line)));

  p_done_after_stop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(kind == K_STOP));

  p_err_needs_nack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> ($past(sda_i) && $past(kind == K_TXB)));

  p_busy_not_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !done_o);

endmodule

// File: rtl/eeprom_mac_reader.sv
module eeprom_mac_reader #(
  parameter int DIV_W      = 8,
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [1:0]              base_sel_i,
  input  logic [DIV_W-1:0]        half_div_i,
  input  logic                    sda_i,
  output logic                    scl_o,
  output logic                    sda_o,
  output logic                    sda_oe_o,
  output logic [8*ADDR_BYTES-1:0] addr_o,
  output logic                    done_o,
  output logic                    err_o
);
  localparam int AW = 8 * ADDR_BYTES;

  logic load, busy, tick, shift;

  eeprom_rd_pace #(.DIV_W(DIV_W)) pace_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .run_i  (busy),
    .div_i  (half_div_i),
    .tick_o (tick)
  );

  eeprom_rd_seq #(.ADDR_BYTES(ADDR_BYTES)) seq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .base_sel_i (base_sel_i),
    .tick_i     (tick),
    .sda_i      (sda_i),
    .load_o     (load),
    .busy_o     (busy),
    .shift_o    (shift),
    .scl_o      (scl_o),
    .sda_o      (sda_o),
    .sda_oe_o   (sda_oe_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  eeprom_rd_capture #(.W(AW)) cap_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load),
    .shift_i (shift),
    .bit_i   (sda_i),
    .data_o  (addr_o)
  );

  p_err_clears_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (addr_o == '0));

endmodule

// File: tb/eeprom_mac_reader_tb_top.sv
module eeprom_mac_reader_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, sda_i = 1'b1;
  logic [1:0]  base_sel_i = '0;
  logic [7:0]  half_div_i = 8'd2;
  logic        scl_o, sda_o, sda_oe_o, done_o, err_o;
  logic [47:0] addr_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [3:0] stp[$];   // {scl, oe, sda, value bench drives on sda_i}
  int         tag[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  eeprom_mac_reader dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .base_sel_i(base_sel_i),
    .half_div_i(half_div_i), .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o),
    .sda_oe_o(sda_oe_o), .addr_o(addr_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic check(input bit ok, input int r, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: got %0h expected %0h", r, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [7:0] exp_base(input int s);
    case (s)
      0: return 8'h83;
      1: return 8'h99;
      2: return 8'hAF;
      default: return 8'hF8;
    endcase
  endfunction

  task automatic push(input logic [3:0] s, input int r);
    stp.push_back(s);
    tag.push_back(r);
  endtask

  // R3 start condition, R12 covered by exact waveform match
  task automatic push_start();
    push(4'b0111, 3); push(4'b1111, 3); push(4'b1101, 3); push(4'b0101, 3);
  endtask

  // R10 stop condition
  task automatic push_stop();
    push(4'b0001, 10); push(4'b1001, 10); push(4'b1101, 10);
    push(4'b1111, 10); push(4'b1011, 10); push(4'b0011, 10);
  endtask

  // R4 byte order, R5 bit steps, R6 ack slot, R7 nack marks tag 7
  task automatic push_tx(input logic [7:0] b, input bit nack);
    for (int i = 7; i >= 0; i--) begin
      push({2'b01, b[i], 1'b1}, 5);
      push({2'b11, b[i], 1'b1}, 4);
    end
    push({3'b000, nack}, 6);
    push({3'b100, nack}, nack ? 7 : 6);
  endtask

  task automatic run(input int sel, input logic [7:0] div, input int nack_at,
                     input logic [47:0] data, input bit poke);
    int per;
    bit exp_err;
    logic [7:0] d;
    stp.delete(); tag.delete();
    per = (div < 2) ? 2 : int'(div);  // R2
    push_start();
    push_tx(8'hA0, nack_at == 1);
    if (nack_at != 1) push_tx(exp_base(sel), nack_at == 2);
    if (nack_at == 0 || nack_at == 3) begin
      push_start();
      push_tx(8'hA1, nack_at == 3);
    end
    if (nack_at == 0) begin
      for (int k = 0; k < 6; k++) begin
        d = data[47 - 8 * k -: 8];
        for (int i = 7; i >= 0; i--) begin  // R8 receive steps
          push({3'b000, d[i]}, 8);
          push({3'b100, d[i]}, 8);
        end
        push({2'b01, (k == 5), 1'b1}, 9);   // R9 master ack / final nack
        push({2'b11, (k == 5), 1'b1}, 9);
      end
    end
    push_stop();

    @(negedge clk);
    base_sel_i = 2'(sel); half_div_i = div; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    exp_err = 0;
    foreach (stp[s]) begin
      for (int c = 0; c < per; c++) begin
        sda_i   = stp[s][0];
        start_i = (poke && s == 30 && c == 0);  // R1 ignored mid-run
        check({scl_o, sda_oe_o, sda_o} == stp[s][3:1], tag[s],
              $sformatf("pins step %0d cyc %0d", s, c),
              {scl_o, sda_oe_o, sda_o}, stp[s][3:1]);
        check(done_o == 1'b0, 11, "done during run", done_o, 0);
        check(err_o == exp_err, 7, "err during run", err_o, exp_err);
        @(negedge clk);
      end
      if (tag[s] == 7) exp_err = 1;
    end
    sda_i = 1'b1; start_i = 1'b0;
    check(done_o == 1'b1, 11, "done after stop", done_o, 1);
    check(err_o == (nack_at != 0), 7, "err after stop", err_o, nack_at != 0);
    check(addr_o == ((nack_at != 0) ? 48'h0 : data), 8, "address", addr_o,
          (nack_at != 0) ? 48'h0 : data);
    repeat (3) begin
      @(negedge clk);
      check({scl_o, sda_oe_o, sda_o} == 3'b000 && done_o, 11, "idle pins",
            {scl_o, sda_oe_o, sda_o, done_o}, 4'b0001);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R11 watchdog expired: got running expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({scl_o, sda_oe_o, sda_o, done_o, err_o} == 5'b0 && addr_o == 48'h0, 11,
          "reset state", {scl_o, sda_oe_o, sda_o, done_o, err_o}, 0);
    rst_ni = 1'b1;
    run(0, 8'd2, 0, 48'h0123_4567_89AB, 0);
    run(1, 8'd0, 0, 48'hA55A_5AA5_C33C, 1);   // R1 start while busy, R2 floor
    run(2, 8'd5, 0, 48'hFFFF_FF00_0000, 0);
    run(3, 8'd3, 0, 48'h8000_0000_0001, 0);
    run(3, 8'd2, 2, 48'h0, 0);                // R7 nack on word address
    run(0, 8'd1, 1, 48'h0, 0);                // R7 nack on write control
    run(2, 8'd2, 3, 48'h0, 0);                // R7 nack on read control
    run(1, 8'd4, 0, 48'h1357_9BDF_2468, 0);   // R1 result replaced on restart
    finished = 1;
    summary();
  end

endmodule